// File: doc/BRIEF.md
# Aperture Address Translator for the Legacy Graphics Window

This block sits between a host memory port and the display-memory controller of a graphics adapter. It runs in the standard graphics mode, where the frame buffer occupies A0000h–AFFFFh. It watches host addresses in the B0000h–BFFFFh range. Three 8 KB translation apertures occupy B8000h–BDFFFh. Each one can be moved anywhere in a 4 MB display memory by its own base pointer. An access through an aperture goes out with a display-memory address equal to that aperture's base pointer plus the offset of the access within the aperture.

A steering bit for each aperture can send its traffic to the accelerator registers instead of to display memory. Two more regions are decoded when memory-mapped registers are enabled:

- an external-register area half the size of an aperture, directly after the last aperture;
- a 256-byte register page at the top of the window, which holds the three base pointers and the steering bits.

Every decode result is registered. The target select and the translated address appear one cycle after the host strobe.

Top module: `mmu_aperture_xlat`

## Requirements
- R1: While reset is held, and after it is released, all four target selects and `xlat_addr` are 0, and `host_rdata` is all ones. All base pointers and steering bits reset to 0.
- R2: When `apt_en` is 1, a strobe to B8000h–B9FFFh, BA000h–BBFFFh or BC000h–BDFFFh hits aperture 0, 1 or 2. If that aperture's steering bit is 0, `sel_mem` is 1 in the cycle after the strobe.
- R3: For an aperture hit, `xlat_addr` equals the aperture's 22-bit base pointer plus the 13-bit offset of the host address within the aperture, modulo 2^22.
- R4: The steering bits for apertures 0, 1 and 2 are bits 24, 25 and 26 of the register word at page offset 10h. When the bit for the hit aperture is 1, `sel_acl` is raised instead of `sel_mem`, with the same translated address.
- R5: Writes to the register words at page offsets 00h, 04h and 08h load the base pointers of apertures 0, 1 and 2. Only data bits 21:0 are kept, and a read returns them with bits 31:22 as 0. Other words in the page read as 0.
- R6: When both `apt_en` and `mmr_en` are 1, a strobe to BE000h–BEFFFh raises `sel_ext`, and `xlat_addr` carries the 12-bit offset within that area.
- R7: When both enables are 1, a strobe to BFF00h–BFFFFh raises `sel_reg`, and `xlat_addr` carries the 8-bit page offset. A read returns the addressed register word on `host_rdata` in the cycle after the strobe.
- R8: When `apt_en` is 0, no strobe raises any select, and register-page writes have no effect.
- R9: When `mmr_en` is 0, the external area and the register page are not decoded and writes to the page are ignored. Apertures still translate.
- R10: A cycle with no strobe, or a strobe that hits no region, gives all selects 0 and `xlat_addr` 0 in the next cycle. `host_rdata` is all ones in every cycle that does not follow a register-page read.
- R11: At most one of the four target selects is 1 in any cycle. When `host_wr` and `host_rd` are both 1, the access is a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| apt_en | input | 1 | Enables aperture decoding |
| mmr_en | input | 1 | Enables the external area and register page (also needs `apt_en`) |
| host_addr | input | 20 | Host memory address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data for register-page words |
| sel_mem | output | 1 | Access goes to display memory |
| sel_acl | output | 1 | Access goes to accelerator registers |
| sel_ext | output | 1 | Access goes to external mapped registers |
| sel_reg | output | 1 | Access hit the register page |
| xlat_addr | output | 22 | Translated address or in-region offset |
| host_rdata | output | 32 | Register-page read data, otherwise all ones |

## Verification
Each result is due exactly one clock edge after its strobe: the selects, `xlat_addr` and `host_rdata`. A register write changes the decode of a strobe issued in the next cycle. The bench drives a strobe on a falling edge and predicts the outputs from its model state before the write. It compares them on the following falling edge. The stimulus covers:

- the first and last byte of each region;
- a base pointer that wraps past 4 MB;
- steering changes;
- each enable held low.

Register contents are read back through the page itself.

// File: rtl/mmu_aperture_xlat.sv
module mmu_aperture_xlat #(
  parameter int HADDR_W   = 20,
  parameter int DADDR_W   = 22,
  parameter int DATA_W    = 32,
  parameter int NUM_APT   = 3,
  parameter int APT_OFS_W = 13,
  parameter int PAGE_W    = 8,
  parameter int CTRL_WORD = 4,
  parameter int CTRL_LSB  = 24,
  parameter logic [HADDR_W-1:0] APT_BASE = 20'hB8000,
  parameter logic [HADDR_W-1:0] REG_PAGE = 20'hBFF00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apt_en,
  input  logic               mmr_en,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic               sel_mem,
  output logic               sel_acl,
  output logic               sel_ext,
  output logic               sel_reg,
  output logic [DADDR_W-1:0] xlat_addr,
  output logic [DATA_W-1:0]  host_rdata
);
  localparam int EXT_OFS_W = APT_OFS_W - 1;
  localparam int APT_TAG_W = HADDR_W - APT_OFS_W;
  localparam int EXT_TAG_W = HADDR_W - EXT_OFS_W;
  localparam int PG_TAG_W  = HADDR_W - PAGE_W;
  localparam int WIDX_W    = PAGE_W - 2;
  localparam logic [HADDR_W-1:0] EXT_BASE =
    APT_BASE + HADDR_W'(NUM_APT) * HADDR_W'(1 << APT_OFS_W);

  logic               strobe, mmr_on, ext_hit, reg_hit, reg_wr, reg_rd;
  logic [WIDX_W-1:0]  widx;
  logic [NUM_APT-1:0] apt_hit, steer_q;
  logic [DADDR_W-1:0] apt_sum [NUM_APT];
  logic [DADDR_W-1:0] base_q  [NUM_APT];
  logic [DADDR_W-1:0] apt_addr;
  logic               apt_any, apt_steer;
  logic [DATA_W-1:0]  rd_word;

  assign strobe  = host_rd | host_wr;
  assign mmr_on  = apt_en & mmr_en;
  assign ext_hit = mmr_on && host_addr[HADDR_W-1:EXT_OFS_W] == EXT_BASE[HADDR_W-1:EXT_OFS_W];
  assign reg_hit = mmr_on && host_addr[HADDR_W-1:PAGE_W] == REG_PAGE[HADDR_W-1:PAGE_W];
  assign widx    = host_addr[PAGE_W-1:2];
  assign reg_wr  = strobe & host_wr & reg_hit;
  assign reg_rd  = strobe & ~host_wr & reg_hit;

  for (genvar i = 0; i < NUM_APT; i++) begin : g_apt
    localparam logic [APT_TAG_W-1:0] TAG =
      APT_BASE[HADDR_W-1:APT_OFS_W] + APT_TAG_W'(i);
    assign apt_hit[i] = apt_en && host_addr[HADDR_W-1:APT_OFS_W] == TAG;
    assign apt_sum[i] = base_q[i] + DADDR_W'(host_addr[APT_OFS_W-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
      end else if (reg_wr && widx == WIDX_W'(i)) begin
        base_q[i] <= host_wdata[DADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) steer_q <= '0;
    else if (reg_wr && widx == WIDX_W'(CTRL_WORD))
      steer_q <= host_wdata[CTRL_LSB +: NUM_APT];
  end

  always_comb begin
    apt_any   = 1'b0;
    apt_steer = 1'b0;
    apt_addr  = '0;
    for (int i = 0; i < NUM_APT; i++) begin
      if (apt_hit[i]) begin
        apt_any   = 1'b1;
        apt_steer = steer_q[i];
        apt_addr  = apt_sum[i];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_APT; i++)
      if (widx == WIDX_W'(i)) rd_word = DATA_W'(base_q[i]);
    if (widx == WIDX_W'(CTRL_WORD)) rd_word = DATA_W'(steer_q) << CTRL_LSB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_mem    <= 1'b0;
      sel_acl    <= 1'b0;
      sel_ext    <= 1'b0;
      sel_reg    <= 1'b0;
      xlat_addr  <= '0;
      host_rdata <= '1;
    end else begin
      sel_mem    <= strobe & apt_any & ~apt_steer;
      sel_acl    <= strobe & apt_any & apt_steer;
      sel_ext    <= strobe & ext_hit;
      sel_reg    <= strobe & reg_hit;
      host_rdata <= reg_rd ? rd_word : '1;
      if (!strobe)      xlat_addr <= '0;
      else if (apt_any) xlat_addr <= apt_addr;
      else if (ext_hit) xlat_addr <= DADDR_W'(host_addr[EXT_OFS_W-1:0]);
      else if (reg_hit) xlat_addr <= DADDR_W'(host_addr[PAGE_W-1:0]);
      else              xlat_addr <= '0;
    end
  end

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mem, sel_acl, sel_ext, sel_reg}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd || host_wr) |=> !(sel_mem || sel_acl || sel_ext || sel_reg) && xlat_addr == '0);

  assert_rdata_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> (sel_reg || host_rdata == '1));

  assert_apt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && !apt_en) |=> !(sel_mem || sel_acl || sel_ext || sel_reg));

  assert_mmr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && !mmr_en) |=> !sel_ext && !sel_reg);

  assert_page_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mmr_en |=> $stable(steer_q));
endmodule

// File: tb/mmu_aperture_xlat_bench.sv
module mmu_aperture_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        apt_en = 1'b0, mmr_en = 1'b0;
  logic [19:0] host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        sel_mem, sel_acl, sel_ext, sel_reg;
  logic [21:0] xlat_addr;
  logic [31:0] host_rdata;

  int checks = 0, errors = 0;
  int base [3];
  int steer = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_aperture_xlat u_mmu_aperture_xlat (
    .clk(clk), .rst_n(rst_n), .apt_en(apt_en), .mmr_en(mmr_en),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .sel_mem(sel_mem), .sel_acl(sel_acl),
    .sel_ext(sel_ext), .sel_reg(sel_reg), .xlat_addr(xlat_addr),
    .host_rdata(host_rdata));

  task automatic compare(string req, logic [3:0] es, int ea, logic [31:0] ed);
    logic [3:0] as = {sel_mem, sel_acl, sel_ext, sel_reg};
    checks++;
    if (as !== es || xlat_addr !== 22'(ea) || host_rdata !== ed) begin
      errors++;
      $display("FAIL %s: sel=%b addr=%h rdata=%h expected sel=%b addr=%h rdata=%h",
               req, as, xlat_addr, host_rdata, es, 22'(ea), ed);
    end
  endtask

  task automatic access(string req, bit rd, bit wr, int addr, int data);
    logic [3:0] es = 4'b0;
    int ea = 0;
    logic [31:0] ed = 32'hFFFF_FFFF;
    bit mon = apt_en && mmr_en;
    bit stb = rd || wr;
    host_addr = 20'(addr); host_rd = rd; host_wr = wr; host_wdata = data;
    if (stb) begin
      for (int i = 0; i < 3; i++)
        if (apt_en && (addr >> 13) == (32'hB8000 >> 13) + i) begin
          es = ((steer >> i) & 1) ? 4'b0100 : 4'b1000;
          ea = (base[i] + (addr & 32'h1FFF)) & 32'h3F_FFFF;
        end
      if (mon && (addr >> 12) == 32'hBE) begin es = 4'b0010; ea = addr & 32'hFFF; end
      if (mon && (addr >> 8) == 32'hBFF) begin
        es = 4'b0001; ea = addr & 32'hFF;
        if (wr) begin
          if (((addr >> 2) & 63) < 3) base[(addr >> 2) & 63] = data & 32'h3F_FFFF;
          if (((addr >> 2) & 63) == 4) steer = (data >> 24) & 7;
        end else begin
          case ((addr >> 2) & 63)
            0, 1, 2: ed = base[(addr >> 2) & 63];
            4: ed = steer << 24;
            default: ed = 0;
          endcase
        end
      end
    end
    @(negedge clk);
    compare(req, es, ea, ed);
    host_rd = 0; host_wr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) base[i] = 0;
    @(negedge clk); @(negedge clk);
    compare("R1 in reset", 4'b0, 0, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 4'b0, 0, 32'hFFFF_FFFF);
    apt_en = 1; mmr_en = 1;
    access("R1 base0 reset read", 1, 0, 32'hBFF00, 0);
    access("R2 aperture0 first byte", 1, 0, 32'hB8000, 0);
    access("R5 write base0", 0, 1, 32'hBFF00, 32'h0010_0000);
    access("R5 write base1", 0, 1, 32'hBFF04, 32'h003F_F000);
    access("R5 write base2 masked", 0, 1, 32'hBFF08, 32'hFFEA_AAAA);
    access("R5 read base2", 1, 0, 32'hBFF08, 0);
    access("R5 read base1", 1, 0, 32'hBFF04, 0);
    access("R5 read unused word", 1, 0, 32'hBFF0C, 0);
    access("R3 aperture0 start", 1, 0, 32'hB8000, 0);
    access("R3 aperture0 end", 0, 1, 32'hB9FFF, 0);
    access("R3 aperture1 start", 1, 0, 32'hBA000, 0);
    access("R3 aperture1 wrap", 1, 0, 32'hBBFFF, 0);
    access("R3 aperture2 mid", 0, 1, 32'hBC123, 0);
    access("R2 aperture2 end", 1, 0, 32'hBDFFF, 0);
    access("R10 below apertures", 1, 0, 32'hB7FFF, 0);
    access("R10 gap before page", 1, 0, 32'hBF000, 0);
    access("R10 frame buffer", 0, 1, 32'hA1234, 0);
    access("R10 idle", 0, 0, 32'hB8000, 0);
    access("R6 ext first", 1, 0, 32'hBE000, 0);
    access("R6 ext last", 0, 1, 32'hBEFFF, 0);
    access("R4 steer ap1", 0, 1, 32'hBFF10, 32'h0200_0000);
    access("R4 read ctrl", 1, 0, 32'hBFF10, 0);
    access("R4 ap1 to accel", 1, 0, 32'hBA010, 0);
    access("R4 ap0 still mem", 1, 0, 32'hB8010, 0);
    access("R4 steer all", 0, 1, 32'hBFF10, 32'hFFFF_FFFF);
    access("R4 ap2 to accel", 0, 1, 32'hBDFFF, 0);
    access("R11 write wins", 1, 1, 32'hBFF10, 32'h0100_0000);
    access("R11 read after", 1, 0, 32'hBFF10, 0);
    access("R7 page last byte", 1, 0, 32'hBFFFF, 0);
    mmr_en = 0;
    access("R9 page write ignored", 0, 1, 32'hBFF00, 32'h0000_1234);
    access("R9 ext not decoded", 1, 0, 32'hBE800, 0);
    access("R9 aperture works", 1, 0, 32'hB8004, 0);
    mmr_en = 1;
    access("R9 base0 unchanged", 1, 0, 32'hBFF00, 0);
    apt_en = 0;
    access("R8 aperture off", 1, 0, 32'hB8000, 0);
    access("R8 page off", 0, 1, 32'hBFF10, 32'h0700_0000);
    access("R8 ext off", 1, 0, 32'hBE000, 0);
    apt_en = 1;
    access("R8 ctrl unchanged", 1, 0, 32'hBFF10, 0);
    access("R7 page read base0", 1, 0, 32'hBFF00, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule